// File: doc/BRIEF.md
# Interrupt Mask and Status Port Block

This block sits on a host processor's 8-bit I/O bus and collects the interrupt sources around it. Three level-sensitive requests (timer, printer, keyboard) pass through a software-written enable mask. A combined external-interrupt line and the enabled requests together drive a registered normal interrupt request. A break-key line and a sub-processor attention line drive a registered fast interrupt request.

Software reads the state back through small ports. The status port shows pending sources active-low, and its unused bits read as ones. A separate fast-interrupt flag port shows the break-key and attention lines, also active-low. A 9-bit keyboard code is captured on a load strobe. Its low eight bits are read from one port, and its ninth bit shares a clock/keyboard port with the fast-clock mode flag.

All port reads are registered. Read data appears on the cycle after the read strobe and holds until the next read.

Top module: `ipx_irq_port`

## Requirements
- R1: A write to port 2 loads the enable mask from data bit 2 (timer), bit 1 (printer) and bit 0 (keyboard); 1 enables and 0 masks, other data bits have no effect, the new mask applies from the cycle after the write, and reset masks all three sources.
- R2: A read of port 3 returns timer in bit 2, printer in bit 1 and keyboard in bit 0, each 0 only while that request is high and enabled, 1 otherwise.
- R3: Bits 7:4 of a port 3 read are always 1.
- R4: Bit 3 of a port 3 read is 0 while the external-interrupt line is high and 1 otherwise, regardless of the mask.
- R5: A read of port 4 returns bit 1 as 0 while break is held, bit 0 as 0 while attention is asserted, and bits 7:2 as 1.
- R6: A pulse on the key load strobe captures the 9-bit key code; a read of port 1 returns its bits 7:0, and the code holds until the next load.
- R7: A read of port 0 returns key-code bit 8 in bit 7, the fast-clock mode input in bit 0, and 1 in bits 6:1.
- R8: The irq output is high on the cycle after any enabled request or the external line is high, and low otherwise.
- R9: The firq output is high on the cycle after break or attention is high, and low otherwise.
- R10: Read data is registered: it appears the cycle after a read strobe and holds while no read occurs. Reads of ports 2, 5, 6 and 7 return 0xFF. Reset clears read data, irq and firq to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Port select |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| req_timer | input | 1 | Timer interrupt request level |
| req_printer | input | 1 | Printer interrupt request level |
| req_keyboard | input | 1 | Keyboard interrupt request level |
| ext_irq | input | 1 | Combined external-interrupt level |
| brk_key | input | 1 | Break key held |
| sub_attn | input | 1 | Sub-processor attention |
| fast_clk_mode | input | 1 | Fast-clock mode flag |
| key_load | input | 1 | Key code capture strobe |
| key_code | input | 9 | Key code to capture |
| irq | output | 1 | Registered normal interrupt request |
| firq | output | 1 | Registered fast interrupt request |

## Verification
The main sweep tries all 8 mask values against all 8 request patterns, each with the external line both low and high. This shows whether each status bit follows its own source and mask bit rather than a neighbour's, and whether the external line reaches irq and status bit 3 past the mask. Mask writes with the upper data bits set and with one-cycle mask changes under a held request check the write decoding and the one-cycle latency. The four break/attention combinations separate the two fast-interrupt bits. Key codes with bit 8 set and clear, together with a load coinciding with a read, show the split of the code across ports and that a read returns the code held before the load.

// File: rtl/ipx_pkg.sv
package ipx_pkg;
  localparam int PORT_AW = 3;

  typedef enum logic [PORT_AW-1:0] {
    PORT_CLKKEY = 3'd0,
    PORT_KEYLO  = 3'd1,
    PORT_MASK   = 3'd2,
    PORT_STATUS = 3'd3,
    PORT_FIFLAG = 3'd4
  } port_e;

  localparam int SRC_KBD = 0;
  localparam int SRC_PRN = 1;
  localparam int SRC_TMR = 2;
  localparam int NUM_SRC = 3;
endpackage

// File: rtl/ipx_mask_reg.sv
module ipx_mask_reg #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [NSRC-1:0] wr_bits,
  output logic [NSRC-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst)        mask <= '0;
    else if (wr_en) mask <= wr_bits;
  end

  assert_mask_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(mask));
endmodule

// File: rtl/ipx_key_latch.sv
module ipx_key_latch #(
  parameter int KEY_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [KEY_W-1:0] code_in,
  output logic [KEY_W-1:0] code
);
  always_ff @(posedge clk) begin
    if (rst)       code <= '0;
    else if (load) code <= code_in;
  end

  assert_key_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(code));
  assert_key_capture_R6: assert property (@(posedge clk) disable iff (rst)
    load |=> (code == $past(code_in)));
endmodule

// File: rtl/ipx_req_gen.sv
module ipx_req_gen #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] mask,
  input  logic            ext,
  input  logic            brk,
  input  logic            attn,
  output logic [NSRC-1:0] pend_n,
  output logic            irq,
  output logic            firq
);
  logic [NSRC-1:0] pend;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign pend[i]   = req[i] & mask[i];
    assign pend_n[i] = ~pend[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq  <= 1'b0;
      firq <= 1'b0;
    end else begin
      irq  <= (|pend) | ext;
      firq <= brk | attn;
    end
  end

  assert_irq_ext_R8: assert property (@(posedge clk) disable iff (rst)
    ext |=> irq);
  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (!ext && ((req & mask) == '0)) |=> !irq);
  assert_firq_set_R9: assert property (@(posedge clk) disable iff (rst)
    (brk || attn) |=> firq);
  assert_firq_clr_R9: assert property (@(posedge clk) disable iff (rst)
    (!brk && !attn) |=> !firq);
endmodule

// File: rtl/ipx_irq_port.sv
module ipx_irq_port #(
  parameter int ADDR_W = ipx_pkg::PORT_AW,
  parameter int DATA_W = 8,
  parameter int NSRC   = ipx_pkg::NUM_SRC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              req_timer,
  input  logic              req_printer,
  input  logic              req_keyboard,
  input  logic              ext_irq,
  input  logic              brk_key,
  input  logic              sub_attn,
  input  logic              fast_clk_mode,
  input  logic              key_load,
  input  logic [DATA_W:0]   key_code,
  output logic              irq,
  output logic              firq
);
  import ipx_pkg::*;

  localparam int KEY_W = DATA_W + 1;
  localparam logic [ADDR_W-1:0] A_CLKKEY = ADDR_W'(PORT_CLKKEY);
  localparam logic [ADDR_W-1:0] A_KEYLO  = ADDR_W'(PORT_KEYLO);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(PORT_MASK);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(PORT_STATUS);
  localparam logic [ADDR_W-1:0] A_FIFLAG = ADDR_W'(PORT_FIFLAG);

  logic [NSRC-1:0]   req_vec, mask, pend_n;
  logic [KEY_W-1:0]  key_q;
  logic [DATA_W-1:0] rd_mux, st_byte, fi_byte, ck_byte;
  logic              unused_wbits;

  assign req_vec[SRC_TMR] = req_timer;
  assign req_vec[SRC_PRN] = req_printer;
  assign req_vec[SRC_KBD] = req_keyboard;
  assign unused_wbits     = ^bus_wdata[DATA_W-1:NSRC];

  ipx_mask_reg #(.NSRC(NSRC)) u_mask (
    .clk(clk), .rst(rst),
    .wr_en(bus_wr && (bus_addr == A_MASK)),
    .wr_bits(bus_wdata[NSRC-1:0]),
    .mask(mask)
  );

  ipx_key_latch #(.KEY_W(KEY_W)) u_key (
    .clk(clk), .rst(rst), .load(key_load), .code_in(key_code), .code(key_q)
  );

  ipx_req_gen #(.NSRC(NSRC)) u_req (
    .clk(clk), .rst(rst), .req(req_vec), .mask(mask), .ext(ext_irq),
    .brk(brk_key), .attn(sub_attn), .pend_n(pend_n), .irq(irq), .firq(firq)
  );

  always_comb begin
    st_byte              = '1;
    st_byte[NSRC-1:0]    = pend_n;
    st_byte[NSRC]        = ~ext_irq;
    fi_byte              = '1;
    fi_byte[1]           = ~brk_key;
    fi_byte[0]           = ~sub_attn;
    ck_byte              = '1;
    ck_byte[DATA_W-1]    = key_q[KEY_W-1];
    ck_byte[0]           = fast_clk_mode;
    unique case (bus_addr)
      A_CLKKEY: rd_mux = ck_byte;
      A_KEYLO:  rd_mux = key_q[DATA_W-1:0];
      A_STATUS: rd_mux = st_byte;
      A_FIFLAG: rd_mux = fi_byte;
      default:  rd_mux = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
  assert_status_top_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr == A_STATUS)) |=> (bus_rdata[DATA_W-1:NSRC+1] == '1));
  assert_status_ext_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr == A_STATUS)) |=> (bus_rdata[NSRC] == !$past(ext_irq)));
endmodule

// File: tb/ipx_irq_port_tb.sv
`timescale 1ns/1ps
module ipx_irq_port_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       req_timer = 0, req_printer = 0, req_keyboard = 0;
  logic       ext_irq = 0, brk_key = 0, sub_attn = 0, fast_clk_mode = 0;
  logic       key_load = 0;
  logic [8:0] key_code = '0;
  logic       irq, firq;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  logic [2:0] m_mask = '0;
  logic [8:0] m_key = '0;
  logic [7:0] e_rdata = '0;
  logic       e_irq = 0, e_firq = 0;
  string      e_tag = "R10";

  always #5 clk = ~clk;

  ipx_irq_port dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .req_timer(req_timer), .req_printer(req_printer), .req_keyboard(req_keyboard),
    .ext_irq(ext_irq), .brk_key(brk_key), .sub_attn(sub_attn),
    .fast_clk_mode(fast_clk_mode), .key_load(key_load), .key_code(key_code),
    .irq(irq), .firq(firq)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] model_read(logic [2:0] a);
    logic [2:0] rq;
    rq = {req_timer, req_printer, req_keyboard};
    case (a)
      3'd0: return {m_key[8], 6'h3F, fast_clk_mode};
      3'd1: return m_key[7:0];
      3'd3: return {4'hF, ~ext_irq, ~(rq & m_mask)};
      3'd4: return {6'h3F, ~brk_key, ~sub_attn};
      default: return 8'hFF;
    endcase
  endfunction

  function automatic string read_tag(logic [2:0] a);
    case (a)
      3'd0: return "R7";
      3'd1: return "R6";
      3'd3: return "R2 R3 R4 R1";
      3'd4: return "R5";
      default: return "R10";
    endcase
  endfunction

  // one clock: model next state from current inputs, then compare after the edge
  task automatic tick();
    e_irq  = ((({req_timer, req_printer, req_keyboard}) & m_mask) != 0) || ext_irq;
    e_firq = brk_key || sub_attn;
    if (bus_rd) begin
      e_rdata = model_read(bus_addr);
      e_tag   = read_tag(bus_addr);
    end else begin
      e_tag = "R10 hold";
    end
    if (bus_wr && bus_addr == 3'd2) m_mask = bus_wdata[2:0];
    if (key_load) m_key = key_code;
    @(posedge clk);
    @(negedge clk);
    check("R8 irq", {7'd0, irq}, {7'd0, e_irq});
    check("R9 firq", {7'd0, firq}, {7'd0, e_firq});
    check(e_tag, bus_rdata, e_rdata);
    bus_rd = 0; bus_wr = 0; key_load = 0;
  endtask

  task automatic wr_port(logic [2:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1; tick();
  endtask

  task automatic rd_port(logic [2:0] a);
    bus_addr = a; bus_rd = 1; tick();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state (R10)
    check("R10 reset rdata", bus_rdata, 8'h00);
    check("R10 reset irq", {7'd0, irq}, 8'h00);
    check("R10 reset firq", {7'd0, firq}, 8'h00);
    rst = 0;
    // reset mask: all masked, requests invisible (R1)
    req_timer = 1; req_printer = 1; req_keyboard = 1;
    rd_port(3'd3);
    tick();
    // exhaustive mask x request x external sweep (R1 R2 R3 R4 R8)
    for (int x = 0; x < 2; x++) begin
      for (int m = 0; m < 8; m++) begin
        wr_port(3'd2, {5'b10101, m[2:0]});
        for (int r = 0; r < 8; r++) begin
          {req_timer, req_printer, req_keyboard} = r[2:0];
          ext_irq = x[0];
          rd_port(3'd3);
          tick();
        end
      end
    end
    ext_irq = 0;
    // mask change latency under a held request (R1 R8)
    {req_timer, req_printer, req_keyboard} = 3'b010;
    wr_port(3'd2, 8'h00);
    bus_addr = 3'd2; bus_wdata = 8'hF8; bus_wr = 1; tick();  // upper bits only
    rd_port(3'd3);
    wr_port(3'd2, 8'h02);
    rd_port(3'd3);
    wr_port(3'd2, 8'h05);
    rd_port(3'd3);
    {req_timer, req_printer, req_keyboard} = 3'b000;
    tick();
    // fast interrupt flags (R5 R9)
    for (int f = 0; f < 4; f++) begin
      {brk_key, sub_attn} = f[1:0];
      rd_port(3'd4);
      tick();
    end
    {brk_key, sub_attn} = 2'b00;
    tick();
    // key latch and clock/key port (R6 R7)
    foreach (key_code[i]) begin end
    key_code = 9'h1A5; key_load = 1; tick();
    key_code = 9'h000;
    rd_port(3'd1);
    fast_clk_mode = 1; rd_port(3'd0);
    fast_clk_mode = 0; rd_port(3'd0);
    key_code = 9'h0FF; key_load = 1; bus_addr = 3'd1; bus_rd = 1; tick(); // old code read
    rd_port(3'd1);
    rd_port(3'd0);
    key_code = 9'h100; key_load = 1; tick();
    fast_clk_mode = 1;
    rd_port(3'd0);
    rd_port(3'd1);
    // unmapped ports and hold (R10)
    for (int a = 5; a < 8; a++) rd_port(a[2:0]);
    rd_port(3'd2);
    rd_port(3'd1);
    repeat (3) tick();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule